// File: doc/BRIEF.md
# Account Table Handshake Responder

This block is the storage side of a teller terminal's account memory. It keeps a small table in which every entry carries a hold flag and a 16-bit unsigned balance. A single requester talks to it over a four-phase request/acknowledge handshake. The requester raises a request with an account number and two qualifiers. The block then does one of three things: it marks the entry as held, returns the stored balance, or replaces the balance with a supplied value. After a fixed memory latency it raises its acknowledge.

A second, combinational path reports the hold flag of whichever entry the current account number selects. The requester can test whether an account is held without running a handshake. The table is indexed by the low bits of the account number. At reset every entry comes up not held and loaded with a configured starting balance. The block performs no arithmetic on balances; it only stores and returns them.

Top module: `acct_store_responder`

## Requirements
- R1: After reset, `done_o` is 0, `amt_o` is 0, and every table entry is not held and holds the balance `INIT_BAL`.
- R2: A request accepted with `lock_i`=1 sets the selected entry's hold flag, leaves its balance unchanged, and is acknowledged.
- R3: A request accepted with `lock_i`=0 and `write_i`=0 drives the selected entry's balance on `amt_o`, valid for as long as `done_o` stays 1.
- R4: A request accepted with `lock_i`=0 and `write_i`=1 stores `amt_i` as the selected entry's new balance before `done_o` rises.
- R5: `done_o` stays 1 while `req_i` is 1. It returns to 0 on the first rising edge at which `req_i` is sampled 0.
- R6: A request is accepted on the rising edge at which `req_i` is first sampled 1 while the block is ready. `done_o` rises on the `WAIT_CYC`-th rising edge after that acceptance edge.
- R7: `lock_i`, `write_i`, `acct_i` and `amt_i` are captured on the acceptance edge. Changes to them later in the same transaction have no effect on that transaction.
- R8: A request is not accepted until `req_i` has been sampled 0 while `done_o` is 0. This applies after reset and after every completed transaction, so a `req_i` held high across either of them is ignored.
- R9: The entry is chosen by the low `IDX_W` bits of the account number (bits 2:0 at the default of 8 entries). Account numbers that differ only above those bits address the same entry.
- R10: `lock_stat_o` equals the hold flag of the entry selected by the current `acct_i`, in the same cycle and with no clock edge in between.
- R11: When `lock_i` and `write_i` are both 1 at acceptance, only the hold flag is set; `amt_i` is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request from the requester (four-phase) |
| lock_i | input | 1 | Qualifier: set the hold flag |
| write_i | input | 1 | Qualifier: store a new balance |
| acct_i | input | ACCT_W (16) | Account number |
| amt_i | input | BAL_W (16) | Balance to store on a write |
| done_o | output | 1 | Acknowledge for the current request |
| amt_o | output | BAL_W (16) | Balance returned by a read |
| lock_stat_o | output | 1 | Hold flag of the entry addressed by `acct_i` (combinational) |

## Verification
The bench builds the block with `WAIT_CYC` = 3 and `INIT_BAL` = 16'h1234. The longer latency keeps the wait counter running through several distinct values, so an off-by-one in the latency shows up as a wrong acknowledge cycle. The non-zero start balance separates a properly initialised entry from a cleared one, and from the values the bench later writes. Eight entries with 16-bit account numbers leave room for aliased numbers, qualifier changes during a transaction, and a request held high across reset or across the end of a transaction.

// File: rtl/acct_pkg.sv
package acct_pkg;

  typedef enum logic [1:0] {
    ST_REARM = 2'd0,
    ST_IDLE  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } hs_state_e;

  typedef enum logic [1:0] {
    OP_LOCK  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } acct_op_e;

  // Qualifier decode: the hold request outranks the write request.
  function automatic acct_op_e pick_op(input logic lock, input logic write);
    if (lock)       return OP_LOCK;
    else if (write) return OP_WRITE;
    else            return OP_READ;
  endfunction

endpackage

// File: rtl/acct_hs_ctrl.sv
module acct_hs_ctrl
  import acct_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int BAL_W    = 16,
  parameter int WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             lock_i,
  input  logic             write_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BAL_W-1:0] amt_i,
  output logic             done_o,
  output logic             commit_o,
  output acct_op_e         op_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [BAL_W-1:0] amt_o
);

  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  hs_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             last_wait;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign last_wait = (state_q == ST_WAIT) && (cnt_q == CNT_LAST);
  assign commit_o  = last_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REARM;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      op_o    <= OP_READ;
      idx_o   <= '0;
      amt_o   <= '0;
    end else begin
      unique case (state_q)
        ST_REARM: if (!req_i) state_q <= ST_IDLE;
        ST_IDLE: if (accept) begin
          op_o    <= pick_op(lock_i, write_i);
          idx_o   <= idx_i;
          amt_o   <= amt_i;
          cnt_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (last_wait) begin
          done_o  <= 1'b1;
          state_q <= ST_DONE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: if (!req_i) begin
          done_o  <= 1'b0;
          state_q <= ST_REARM;
        end
        default: state_q <= ST_REARM;
      endcase
    end
  end

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_i) |=> done_o);

  // R5
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !req_i) |=> !done_o);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(commit_o));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!done_o && !commit_o));

endmodule

// File: rtl/acct_table.sv
module acct_table #(
  parameter int             IDX_W    = 3,
  parameter int             BAL_W    = 16,
  parameter logic [15:0]    INIT_BAL = 16'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_we_i,
  input  logic             bal_we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [BAL_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [BAL_W-1:0] rd_bal_o,
  output logic             lk_stat_o
);

  localparam int N_ENT = 1 << IDX_W;

  logic             lock_q [N_ENT];
  logic [BAL_W-1:0] bal_q  [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = (widx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[g] <= 1'b0;
        bal_q[g]  <= BAL_W'(INIT_BAL);
      end else begin
        if (lock_we_i && hit) lock_q[g] <= 1'b1;
        if (bal_we_i && hit)  bal_q[g]  <= wdata_i;
      end
    end
  end

  assign rd_bal_o  = bal_q[widx_i];
  assign lk_stat_o = lock_q[lk_idx_i];

  // R2
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we_i |=> lock_q[$past(widx_i)]);

  // R4
  bal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bal_we_i |=> (bal_q[$past(widx_i)] == $past(wdata_i)));

  // R11
  lock_keeps_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we_i && !bal_we_i) |=> $stable(bal_q[$past(widx_i)]));

endmodule

// File: rtl/acct_store_responder.sv
module acct_store_responder
  import acct_pkg::*;
#(
  parameter int          ACCT_W   = 16,
  parameter int          BAL_W    = 16,
  parameter int          IDX_W    = 3,
  parameter int          WAIT_CYC = 2,
  parameter logic [15:0] INIT_BAL = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              lock_i,
  input  logic              write_i,
  input  logic [ACCT_W-1:0] acct_i,
  input  logic [BAL_W-1:0]  amt_i,
  output logic              done_o,
  output logic [BAL_W-1:0]  amt_o,
  output logic              lock_stat_o
);

  acct_op_e         op_q;
  logic             commit;
  logic [IDX_W-1:0] idx_q;
  logic [BAL_W-1:0] amt_q;
  logic [BAL_W-1:0] rd_bal;
  logic             lock_we, bal_we, rd_commit;
  logic             acct_hi_unused;

  assign acct_hi_unused = ^acct_i[ACCT_W-1:IDX_W];

  acct_hs_ctrl #(
    .IDX_W(IDX_W), .BAL_W(BAL_W), .WAIT_CYC(WAIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .lock_i   (lock_i),
    .write_i  (write_i),
    .idx_i    (acct_i[IDX_W-1:0]),
    .amt_i    (amt_i),
    .done_o   (done_o),
    .commit_o (commit),
    .op_o     (op_q),
    .idx_o    (idx_q),
    .amt_o    (amt_q)
  );

  assign lock_we   = commit && (op_q == OP_LOCK);
  assign bal_we    = commit && (op_q == OP_WRITE);
  assign rd_commit = commit && (op_q == OP_READ);

  acct_table #(
    .IDX_W(IDX_W), .BAL_W(BAL_W), .INIT_BAL(INIT_BAL)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_we_i (lock_we),
    .bal_we_i  (bal_we),
    .widx_i    (idx_q),
    .wdata_i   (amt_q),
    .lk_idx_i  (acct_i[IDX_W-1:0]),
    .rd_bal_o  (rd_bal),
    .lk_stat_o (lock_stat_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         amt_o <= '0;
    else if (rd_commit) amt_o <= rd_bal;
  end

  // R3
  rd_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_commit |=> (amt_o == $past(rd_bal)));

  // R3
  rd_amt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !commit) |=> $stable(amt_o));

endmodule

// File: tb/acct_store_responder_tb.sv
module acct_store_responder_tb_top;

  localparam int          WAITC = 3;
  localparam logic [15:0] IBAL  = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, lock_i = 1'b0, write_i = 1'b0;
  logic [15:0] acct_i = '0, amt_i = '0;
  logic        done_o, lock_stat_o;
  logic [15:0] amt_o;

  always #2 clk = ~clk;

  acct_store_responder #(
    .ACCT_W(16), .BAL_W(16), .IDX_W(3), .WAIT_CYC(WAITC), .INIT_BAL(IBAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
    .write_i(write_i), .acct_i(acct_i), .amt_i(amt_i),
    .done_o(done_o), .amt_o(amt_o), .lock_stat_o(lock_stat_o)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference: phase 0 waiting for req low, 1 ready, 2 busy, 3 acknowledged
  int ref_lock [8];
  int ref_bal  [8];
  int m_phase, m_left, m_op, m_idx, m_val, m_amt;
  bit m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (ref_lock[i]) begin ref_lock[i] = 0; ref_bal[i] = IBAL; end
      m_phase = 0; m_done = 0; m_amt = 0; m_left = 0; m_op = 1; m_idx = 0; m_val = 0;
    end else begin
      case (m_phase)
        0: if (!req_i) m_phase = 1;
        1: if (req_i) begin
             m_op  = lock_i ? 0 : (write_i ? 2 : 1);
             m_idx = acct_i % 8;
             m_val = amt_i;
             m_left = WAITC;
             m_phase = 2;
           end
        2: begin
             m_left--;
             if (m_left == 0) begin
               if (m_op == 0) ref_lock[m_idx] = 1;
               else if (m_op == 2) ref_bal[m_idx] = m_val;
               else m_amt = ref_bal[m_idx];
               m_done = 1;
               m_phase = 3;
             end
           end
        default: if (!req_i) begin m_done = 0; m_phase = 0; end
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      chk("R5/R6/R8 done_o vs model", done_o, m_done);
      chk("R10 lock_stat_o vs model", lock_stat_o, ref_lock[acct_i % 8]);
      if (m_done && m_op == 1) chk("R3 amt_o vs model", amt_o, m_amt);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  logic [15:0] got;

  task automatic txn(input logic [15:0] a, input logic lk, input logic wr,
                     input logic [15:0] v, input bit disturb, output logic [15:0] rd);
    @(posedge clk); #1;
    acct_i = a; lock_i = lk; write_i = wr; amt_i = v; req_i = 1'b1;
    if (disturb) begin
      @(posedge clk); #1;
      acct_i = ~a; lock_i = ~lk; write_i = ~wr; amt_i = ~v;
    end
    for (int k = 0; k < 50 && !done_o; k++) begin @(posedge clk); #1; end
    rd = amt_o;
    req_i = 1'b0;
    for (int k = 0; k < 50 && done_o; k++) begin @(posedge clk); #1; end
    acct_i = a; lock_i = 0; write_i = 0;
    @(posedge clk); #1;
  endtask

  task automatic peek_lock(input logic [15:0] a, input logic exp, input string tag);
    @(posedge clk); #1; acct_i = a;
    @(negedge clk); chk(tag, lock_stat_o, exp);
  endtask

  initial begin
    // R8: request held high through reset and after it
    req_i = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done_o after reset", done_o, 0);
    chk("R1 amt_o after reset", amt_o, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 req held over reset not accepted", done_o, 0);
    #1 req_i = 1'b0;

    // R1: initial table contents
    for (int i = 0; i < 8; i++) begin
      peek_lock(16'(i), 1'b0, "R1 entry unlocked after reset");
      txn(16'(i), 0, 0, 16'h0, 0, got);
      chk("R1 initial balance", got, IBAL);
    end

    // R4: write then read back
    txn(16'd2, 0, 1, 16'hBEEF, 0, got);
    txn(16'd2, 0, 0, 16'h0, 0, got);
    chk("R4 written balance read back", got, 16'hBEEF);
    txn(16'd7, 0, 1, 16'h0000, 0, got);
    txn(16'd7, 0, 0, 16'hFFFF, 0, got);
    chk("R4 zero balance stored", got, 16'h0000);

    // R2: hold flag set, balance untouched
    txn(16'd5, 1, 0, 16'h0, 0, got);
    peek_lock(16'd5, 1'b1, "R2 hold flag set");
    txn(16'd5, 0, 0, 16'h0, 0, got);
    chk("R2 balance unchanged by hold", got, IBAL);

    // R11: hold outranks write
    txn(16'd3, 1, 1, 16'h5555, 0, got);
    peek_lock(16'd3, 1'b1, "R11 hold flag set on lock+write");
    txn(16'd3, 0, 0, 16'h0, 0, got);
    chk("R11 amt_i not stored on lock+write", got, IBAL);

    // R9: aliasing on the low three bits
    txn(16'h0009, 0, 1, 16'h0A0A, 0, got);
    txn(16'h0001, 0, 0, 16'h0, 0, got);
    chk("R9 alias 0x0009 -> entry 1", got, 16'h0A0A);
    txn(16'h0106, 1, 0, 16'h0, 0, got);
    peek_lock(16'h0006, 1'b1, "R9 alias 0x0106 -> entry 6");
    peek_lock(16'hFFF9, 1'b0, "R10 lookup through high bits");

    // R7: qualifiers changed mid-transaction are ignored
    txn(16'd4, 0, 1, 16'h4444, 1, got);
    txn(16'd4, 0, 0, 16'h0, 0, got);
    chk("R7 captured write survives disturbance", got, 16'h4444);
    peek_lock(16'd4, 1'b0, "R7 late lock_i ignored");
    txn(16'd0, 0, 0, 16'h0, 1, got);
    chk("R7 captured read address", got, IBAL);

    // R6: latency from request to acknowledge
    @(posedge clk); #1;
    acct_i = 16'd2; lock_i = 0; write_i = 0; req_i = 1'b1;
    begin
      int edges;
      edges = 0;
      while (!done_o && edges < 50) begin @(posedge clk); #1; edges++; end
      chk("R6 edges from request to done_o", edges, WAITC + 1);
      chk("R3 read value at done_o", amt_o, 16'hBEEF);
    end

    // R5 / R8: req dropped for a single cycle, then raised while done_o falls
    req_i = 1'b0;
    @(posedge clk); #1;
    chk("R5 done_o drops after req low", done_o, 0);
    req_i = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R8 re-raised req without low gap ignored", done_o, 0);
    #1 req_i = 1'b0;
    @(posedge clk); #1;
    txn(16'd2, 0, 0, 16'h0, 0, got);
    chk("R8 accepted after proper rearm", got, 16'hBEEF);

    // R10: combinational lookup tracks acct_i within a cycle
    peek_lock(16'd3, 1'b1, "R10 lookup entry 3");
    peek_lock(16'd1, 1'b0, "R10 lookup entry 1");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule